// File: doc/BRIEF.md
# Serial-Bus Byte Memory Slave

This block is a slave on a two-wire serial bus that follows the I2C protocol. It fronts a 1024-byte memory built from on-chip registers. The clock and data lines are sampled in the system clock domain. The block recognises bus START and STOP conditions and decodes the device byte. It then writes bytes into memory, or reads bytes out of it, while a 10-bit pointer steps forward on its own after each byte. The block pulls the data line low through a single pull-enable output. An external pull-up and the bus wiring form the wired-AND line.

The device byte has two purposes. It selects the device with a fixed five-bit prefix. It also carries the two upper pointer bits and the transfer direction. In a write transfer, the next byte sets the lower eight pointer bits. Any bytes after that are stored. A write transfer that ends right after the pointer byte only positions the pointer for a later read. A lock input held high stops the memory from being changed.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset the pull output is low (line released), every memory byte reads 0 and the pointer is 0.
- R2: A device byte whose bits 7..3 equal 10101 (values A8h to AFh) is acknowledged. Any other device byte is not acknowledged, and the slave leaves the line released until the next START or STOP.
- R3: Bit 0 of the device byte selects the direction: 0 is a write transfer and 1 is a read transfer.
- R4: Device byte bits 2..1 load pointer bits 9..8, for reads as well as writes. In a write transfer, the second byte loads pointer bits 7..0 and is acknowledged.
- R5: In a write transfer with the lock low, each data byte after the pointer byte is acknowledged and stored at the pointer, and the pointer then steps by one.
- R6: The pointer wraps from 1023 to 0, both in write bursts and in read bursts.
- R7: A write transfer that stops after the pointer byte changes no memory. A later read transfer starts at that pointer.
- R8: In a read transfer the slave sends the byte at the pointer MSB first and then steps the pointer. It changes the line only while the clock is low. It sends further bytes while the master acknowledges. After a master non-acknowledge it leaves the line released.
- R9: While the lock input is high, the device byte and pointer byte are still acknowledged. Data bytes are not acknowledged, are not stored and do not step the pointer.
- R10: START is data falling while the clock is high, and STOP is data rising while the clock is high. A repeated START restarts device-byte decoding. After STOP, clocked bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| wr_lock_i | input | 1 | High blocks every memory write |
| sda_pull_o | output | 1 | High pulls the data line low |

## Verification
Some properties are checked on every cycle. The pull output may change only after a synchronized clock fall, a START or a STOP. A START always returns the controller to device-byte decoding. The ignore state never pulls the line. A locked data byte is never acknowledged, and every store steps the pointer by one. Other behaviour can only be shown by the bench's bus transfers. These include the stored values, page selection by the device byte, wrap at the pointer's top, pointer-only writes followed by reads, and repeated-START random reads. They also include MSB-first ordering, which the bench shows with bytes such as 01h and 80h.

// File: rtl/smem_pkg.sv
package smem_pkg;
    localparam int BYTE_W = 8;
    localparam int PAGE_W = 2;
    localparam int ADDR_W = BYTE_W + PAGE_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PFX_W  = BYTE_W - 1 - PAGE_W;
    localparam logic [PFX_W-1:0] DEV_PFX = 5'b10101;
    localparam int CNT_W  = 4;

    typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_TX, ST_SKIP} phase_e;
    typedef enum logic [1:0] {FLD_DEV, FLD_WORD, FLD_DATA} field_e;

    typedef struct packed {
        phase_e             phase;
        field_e             field;
        logic [CNT_W-1:0]   bitn;
        logic [BYTE_W-1:0]  shf;
        logic [ADDR_W-1:0]  ptr;
        logic               rd;
        logic               pull;
    } ctl_t;
endpackage

// File: rtl/smem_line_sync.sv
module smem_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_sr_q, sda_sr_q;
    logic              scl_prev_q, sda_prev_q;
    logic              scl_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr_q   <= '1;
            sda_sr_q   <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sr_q   <= {scl_sr_q[STAGES-2:0], scl_i};
            sda_sr_q   <= {sda_sr_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_sr_q[STAGES-1];
            sda_prev_q <= sda_sr_q[STAGES-1];
        end
    end

    assign scl_now  = scl_sr_q[STAGES-1];
    assign sda_o    = sda_sr_q[STAGES-1];
    assign scl_rise = scl_now & ~scl_prev_q;
    assign scl_fall = ~scl_now & scl_prev_q;
    // clock must be high in both samples so a simultaneous clock/data move is no condition
    assign start_o  = scl_now & scl_prev_q & ~sda_o & sda_prev_q;
    assign stop_o   = scl_now & scl_prev_q & sda_o & ~sda_prev_q;
endmodule

// File: rtl/smem_array.sv
module smem_array #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int N = 1 << AW;
    logic [DW-1:0] cell_q [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) cell_q[i] <= '0;
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import smem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wr_lock_i,
    output logic sda_pull_o
);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] END_SLOT = ACK_SLOT + 1'b1;

    ctl_t              q, d;
    logic              sda_w, rise_w, fall_w, start_w, stop_w;
    logic              mem_we;
    logic [BYTE_W-1:0] rd_byte;
    logic [2:0]        bit_idx;

    smem_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_o(sda_w), .scl_rise(rise_w), .scl_fall(fall_w),
        .start_o(start_w), .stop_o(stop_w)
    );

    smem_array #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(q.ptr),
        .wdata(q.shf), .raddr(q.ptr), .rdata(rd_byte)
    );

    assign bit_idx = 3'(ACK_SLOT - 1'b1 - q.bitn);

    always_comb begin
        d      = q;
        mem_we = 1'b0;
        if (stop_w) begin
            d.phase = ST_IDLE;
            d.pull  = 1'b0;
        end else if (start_w) begin
            d.phase = ST_RX;
            d.field = FLD_DEV;
            d.bitn  = '0;
            d.pull  = 1'b0;
        end else begin
            case (q.phase)
                ST_RX: begin
                    if (rise_w && q.bitn < ACK_SLOT) begin
                        d.shf  = {q.shf[BYTE_W-2:0], sda_w};
                        d.bitn = q.bitn + 1'b1;
                    end else if (fall_w && q.bitn == ACK_SLOT) begin
                        d.bitn = END_SLOT;
                        case (q.field)
                            FLD_DEV: begin
                                if (q.shf[BYTE_W-1 -: PFX_W] == DEV_PFX) begin
                                    d.pull = 1'b1;
                                    d.rd   = q.shf[0];
                                    d.ptr[ADDR_W-1 -: PAGE_W] = q.shf[PAGE_W:1];
                                end else begin
                                    d.phase = ST_SKIP;
                                end
                            end
                            FLD_WORD: begin
                                d.pull = 1'b1;
                                d.ptr[BYTE_W-1:0] = q.shf;
                            end
                            default: begin
                                if (!wr_lock_i) begin
                                    mem_we = 1'b1;
                                    d.ptr  = q.ptr + 1'b1;
                                    d.pull = 1'b1;
                                end
                            end
                        endcase
                    end else if (fall_w && q.bitn == END_SLOT) begin
                        d.pull = 1'b0;
                        if (q.field == FLD_DEV && q.rd) begin
                            d.phase = ST_TX;
                            d.shf   = rd_byte;
                            d.ptr   = q.ptr + 1'b1;
                            d.pull  = ~rd_byte[BYTE_W-1];
                            d.bitn  = CNT_W'(1);
                        end else begin
                            d.field = (q.field == FLD_DEV) ? FLD_WORD : FLD_DATA;
                            d.bitn  = '0;
                        end
                    end
                end
                ST_TX: begin
                    if (fall_w && q.bitn < ACK_SLOT) begin
                        d.pull = ~q.shf[bit_idx];
                        d.bitn = q.bitn + 1'b1;
                    end else if (fall_w && q.bitn == ACK_SLOT) begin
                        d.pull = 1'b0;
                        d.bitn = END_SLOT;
                    end else if (rise_w && q.bitn == END_SLOT && sda_w) begin
                        d.phase = ST_SKIP;
                    end else if (fall_w && q.bitn == END_SLOT) begin
                        d.shf  = rd_byte;
                        d.ptr  = q.ptr + 1'b1;
                        d.pull = ~rd_byte[BYTE_W-1];
                        d.bitn = CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_pull_o = q.pull;

    p_pull_on_low_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull_o) && !$past(start_w || stop_w)) |-> $past(fall_w));

    p_start_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_w && !stop_w) |=> (q.phase == ST_RX && q.field == FLD_DEV && q.bitn == '0));

    p_skip_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == ST_SKIP) |-> !sda_pull_o);

    p_lock_no_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock_i && q.phase == ST_RX && q.field == FLD_DATA && fall_w
         && q.bitn == ACK_SLOT && !start_w && !stop_w) |=> !sda_pull_o);

    // store steps pointer by one, wrapping at the top (R6)
    p_store_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (q.ptr == ADDR_W'($past(q.ptr) + 1'b1)));
endmodule

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;
    localparam int CLK_NS = 10;
    localparam int Q      = 8;
    localparam int LIMIT  = 190000;
    // {page[1:0], low pointer[7:0], data[7:0]}
    localparam logic [17:0] VEC [6] = '{18'h0405A, 18'h110C3, 18'h28001,
                                        18'h37FFF, 18'h11196, 18'h20080};

    logic clk = 1'b0, rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1, lock = 1'b0;
    logic pull, sda_line;
    int   n_cmp = 0, n_bad = 0;
    bit   done = 1'b0;

    assign sda_line = m_sda & ~pull;
    always #(CLK_NS/2) clk = ~clk;

    i2c_mem_slave dut (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
                       .wr_lock_i(lock), .sda_pull_o(pull));

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pause(); repeat (Q) @(negedge clk); endtask
    task automatic bus_start();
        m_sda = 1'b1; pause(); m_scl = 1'b1; pause();
        m_sda = 1'b0; pause(); m_scl = 1'b0; pause();
    endtask
    task automatic bus_stop();
        m_sda = 1'b0; pause(); m_scl = 1'b1; pause(); m_sda = 1'b1; pause();
    endtask
    task automatic put_bit(input bit b);
        m_sda = b; pause(); m_scl = 1'b1; pause(); m_scl = 1'b0; pause();
    endtask
    task automatic get_bit(output bit b);
        m_sda = 1'b1; pause(); m_scl = 1'b1;
        repeat (Q/2) @(negedge clk);
        b = sda_line;
        repeat (Q/2) @(negedge clk);
        m_scl = 1'b0; pause();
    endtask
    task automatic send_byte(input logic [7:0] v, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = !b;
    endtask
    task automatic recv_byte(input bit ack, output logic [7:0] v);
        bit b;
        for (int i = 0; i < 8; i++) begin get_bit(b); v = {v[6:0], b}; end
        put_bit(!ack);
    endtask
    function automatic logic [7:0] dev(input logic [1:0] pg, input bit rd);
        return {5'b10101, pg, rd};
    endfunction
    task automatic rd_random(input string tag, input logic [1:0] pg, input logic [7:0] lo,
                             input logic [7:0] exp);
        bit a; logic [7:0] v;
        bus_start(); send_byte(dev(pg, 1'b0), a); send_byte(lo, a);
        bus_start(); send_byte(dev(pg, 1'b1), a);
        chk({tag, " R10 repeated START read ack"}, a, 1);
        recv_byte(1'b0, v); bus_stop();
        chk({tag, " R3 R8 read data"}, v, exp);
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit a; logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        pause();
        // R1 reset state
        chk("R1 pull released", pull, 0);
        rd_random("R1 zero memory", 2'd0, 8'h05, 8'h00);

        // R2 foreign device bytes
        bus_start(); send_byte(8'hA0, a); chk("R2 A0 not acked", a, 0);
        send_byte(8'h00, a); chk("R2 ignored after mismatch", a, 0);
        bus_stop();
        bus_start(); send_byte(8'hB8, a); chk("R2 B8 not acked", a, 0); bus_stop();

        // table walk: single writes then random reads (R3 R4 R5)
        for (int k = 0; k < 6; k++) begin
            bit a0, a1, a2;
            bus_start();
            send_byte(dev(VEC[k][17:16], 1'b0), a0);
            send_byte(VEC[k][15:8], a1);
            send_byte(VEC[k][7:0], a2);
            bus_stop();
            chk("R2 R4 device ack", a0, 1);
            chk("R4 pointer byte ack", a1, 1);
            chk("R5 data ack", a2, 1);
            rd_random("vec", VEC[k][17:16], VEC[k][15:8], VEC[k][7:0]);
        end
        // R8 sequential read across earlier separate writes
        bus_start(); send_byte(dev(2'd1, 1'b0), a); send_byte(8'h10, a);
        bus_start(); send_byte(dev(2'd1, 1'b1), a);
        recv_byte(1'b1, v); chk("R8 seq byte0", v, 8'hC3);
        recv_byte(1'b0, v); chk("R8 seq byte1", v, 8'h96);
        bus_stop();

        // R6 wrap in write burst and read burst
        bus_start(); send_byte(dev(2'd3, 1'b0), a); send_byte(8'hFE, a);
        send_byte(8'h11, a); chk("R5 burst ack0", a, 1);
        send_byte(8'h22, a); send_byte(8'h33, a); send_byte(8'h44, a);
        chk("R6 ack after wrap", a, 1);
        bus_stop();
        bus_start(); send_byte(dev(2'd3, 1'b0), a); send_byte(8'hFE, a);
        bus_start(); send_byte(dev(2'd3, 1'b1), a);
        recv_byte(1'b1, v); chk("R6 rd 3FE", v, 8'h11);
        recv_byte(1'b1, v); chk("R6 rd 3FF", v, 8'h22);
        recv_byte(1'b1, v); chk("R6 rd 000", v, 8'h33);
        recv_byte(1'b0, v); chk("R6 rd 001", v, 8'h44);
        bus_stop();

        // R7 pointer-only write then current read; R8 release after NACK
        bus_start(); send_byte(dev(2'd3, 1'b0), a); send_byte(8'h7F, a); bus_stop();
        bus_start(); send_byte(dev(2'd3, 1'b1), a);
        recv_byte(1'b0, v); chk("R7 current read", v, 8'hFF);
        get_bit(a); chk("R8 released after NACK", a, 1);
        bus_stop();

        // R9 lock
        lock = 1'b1;
        bus_start(); send_byte(dev(2'd1, 1'b0), a); chk("R9 device ack", a, 1);
        send_byte(8'h10, a); chk("R9 pointer ack", a, 1);
        send_byte(8'hEE, a); chk("R9 data not acked", a, 0);
        bus_stop();
        lock = 1'b0;
        bus_start(); send_byte(dev(2'd1, 1'b1), a);
        recv_byte(1'b0, v); bus_stop();
        chk("R9 memory and pointer kept", v, 8'hC3);

        // R10 bytes after STOP ignored
        m_scl = 1'b0; pause();
        send_byte(8'hA8, a); chk("R10 idle after STOP", a, 0);
        bus_stop();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule